// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit bidirectional buses, A and B. Each direction has a capture register with its own rising-edge clock. The A register samples the A pad, and the B register samples the B pad. Each outgoing path has a multiplexer that forwards either the live value of the opposite pad or the contents of the register that belongs to that direction. An active-low output enable and a direction select decide which bus is driven, if any.

The pads are modelled as three ports per bus, so the block stays synthesizable:
- an input carrying the resolved pad value,
- an output carrying the value to drive,
- a drive-enable output.

The surrounding logic builds the actual tri-state pad. Registers capture on every edge of their clock, whatever the output controls are doing. Software or a sequencer can therefore park data in either register while both buses are isolated, and replay it later. An added active-low asynchronous reset clears both registers.

Top module: `dual_bus_xcvr`

## Requirements
- R1: An active-low `rstN` clears both capture registers to zero at once, without waiting for a clock edge.
- R2: On a rising edge of `capClkA`, the A register loads the value present on `busAIn`.
- R3: On a rising edge of `capClkB`, the B register loads the value present on `busBIn`.
- R4: Capture is never gated. Both registers load on their clock edges even while `outEnN` is 1 and no bus is driven.
- R5: While `outEnN` is 1, `busADrv` and `busBDrv` are both 0.
- R6: While `outEnN` is 0 and `dirAtoB` is 1, `busBDrv` is 1 and `busADrv` is 0.
- R7: While `outEnN` is 0 and `dirAtoB` is 0, `busADrv` is 1 and `busBDrv` is 0.
- R8: `busBOut` equals the live `busAIn` when `selStoredAB` is 0, and the A register contents when `selStoredAB` is 1.
- R9: `busAOut` equals the live `busBIn` when `selStoredBA` is 0, and the B register contents when `selStoredBA` is 1.
- R10: `busADrv` and `busBDrv` are never 1 at the same time.
- R11: A register can capture the value the block is itself driving onto its own bus. This gives load-and-pass-through in a single operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rstN | input | 1 | Asynchronous active-low clear of both registers |
| capClkA | input | 1 | Rising edge loads the A register from the A pad |
| capClkB | input | 1 | Rising edge loads the B register from the B pad |
| outEnN | input | 1 | Active-low output enable; 1 isolates both buses |
| dirAtoB | input | 1 | 1: drive B from the A side; 0: drive A from the B side |
| selStoredAB | input | 1 | Source for B: 0 live A, 1 A register |
| selStoredBA | input | 1 | Source for A: 0 live B, 1 B register |
| busAIn | input | 8 | Resolved value seen on the A pad |
| busAOut | output | 8 | Value to place on the A pad when driving |
| busADrv | output | 1 | High when the A pad must be driven |
| busBIn | input | 8 | Resolved value seen on the B pad |
| busBOut | output | 8 | Value to place on the B pad when driving |
| busBDrv | output | 1 | High when the B pad must be driven |

## Verification
The bench walks the output controls through isolation and both directions. It checks that exactly the expected bus is enabled and that the two enables never overlap. Live forwarding is checked with a change on the source pad between checks, which separates a transparent path from one that latched. Stored forwarding is checked by loading a register, then altering the live pad. A wrong mux select then shows up as the new pad value instead of the held one. Further runs:
- Loads made while isolated, replayed afterwards, expose any gating of capture by the enable.
- A load of a bus the block is driving itself confirms that the register sees the resolved pad.
- A mid-run reset separates a synchronous clear from an asynchronous one.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  // Strobes passed from the control decoder to the datapath
  typedef struct packed {
    logic driveA;          // A pad is the output
    logic driveB;          // B pad is the output
    logic pickStoredForA;  // A path forwards B register contents
    logic pickStoredForB;  // B path forwards A register contents
  } xcvrStrobes_t;

endpackage

// File: rtl/xcvr_ctrl.sv
module xcvr_ctrl
  import xcvr_pkg::*;
(
  input  logic         outEnN,
  input  logic         dirAtoB,
  input  logic         selStoredAB,
  input  logic         selStoredBA,
  output xcvrStrobes_t strobes
);

  logic outputsOn;

  always_comb begin
    outputsOn              = ~outEnN;
    strobes.driveB         = outputsOn & dirAtoB;
    strobes.driveA         = outputsOn & ~dirAtoB;
    strobes.pickStoredForB = selStoredAB;
    strobes.pickStoredForA = selStoredBA;
  end

endmodule

// File: rtl/xcvr_datapath.sv
module xcvr_datapath
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             capClkA,
  input  logic             capClkB,
  input  logic [WIDTH-1:0] busAIn,
  input  logic [WIDTH-1:0] busBIn,
  input  xcvrStrobes_t     strobes,
  output logic [WIDTH-1:0] busAOut,
  output logic [WIDTH-1:0] busBOut,
  output logic             busADrv,
  output logic             busBDrv
);

  localparam int LANES = 2;  // lane 0: A to B, lane 1: B to A

  logic [WIDTH-1:0] laneIn  [LANES];
  logic [WIDTH-1:0] laneOut [LANES];
  logic [LANES-1:0] laneClk;
  logic [LANES-1:0] lanePick;

  assign laneIn[0] = busAIn;
  assign laneIn[1] = busBIn;
  assign laneClk   = {capClkB, capClkA};
  assign lanePick  = {strobes.pickStoredForA, strobes.pickStoredForB};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [WIDTH-1:0] held;

    always_ff @(posedge laneClk[i] or negedge rstN) begin
      if (!rstN) held <= '0;
      else       held <= laneIn[i];
    end

    assign laneOut[i] = lanePick[i] ? held : laneIn[i];
  end

  assign busBOut = laneOut[0];
  assign busAOut = laneOut[1];
  assign busADrv = strobes.driveA;
  assign busBDrv = strobes.driveB;

endmodule

// File: rtl/dual_bus_xcvr.sv
module dual_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             rstN,
  input  logic             capClkA,
  input  logic             capClkB,
  input  logic             outEnN,
  input  logic             dirAtoB,
  input  logic             selStoredAB,
  input  logic             selStoredBA,
  input  logic [WIDTH-1:0] busAIn,
  output logic [WIDTH-1:0] busAOut,
  output logic             busADrv,
  input  logic [WIDTH-1:0] busBIn,
  output logic [WIDTH-1:0] busBOut,
  output logic             busBDrv
);

  xcvrStrobes_t strobes;

  xcvr_ctrl u_ctrl (
    .outEnN      (outEnN),
    .dirAtoB     (dirAtoB),
    .selStoredAB (selStoredAB),
    .selStoredBA (selStoredBA),
    .strobes     (strobes)
  );

  xcvr_datapath #(.WIDTH(WIDTH)) u_dp (
    .rstN    (rstN),
    .capClkA (capClkA),
    .capClkB (capClkB),
    .busAIn  (busAIn),
    .busBIn  (busBIn),
    .strobes (strobes),
    .busAOut (busAOut),
    .busBOut (busBOut),
    .busADrv (busADrv),
    .busBDrv (busBDrv)
  );

endmodule

// File: rtl/dual_bus_xcvr_checker.sv
module dual_bus_xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             rstN,
  input logic             capClkA,
  input logic             capClkB,
  input logic             outEnN,
  input logic             dirAtoB,
  input logic             selStoredAB,
  input logic             selStoredBA,
  input logic [WIDTH-1:0] busAIn,
  input logic [WIDTH-1:0] busAOut,
  input logic             busADrv,
  input logic [WIDTH-1:0] busBIn,
  input logic [WIDTH-1:0] busBOut,
  input logic             busBDrv
);

  p_one_driver_a_r10: assert property (@(posedge capClkA) disable iff (!rstN)
    !(busADrv && busBDrv));

  p_one_driver_b_r10: assert property (@(posedge capClkB) disable iff (!rstN)
    !(busADrv && busBDrv));

  p_isolate_r5: assert property (@(posedge capClkA) disable iff (!rstN)
    outEnN |-> (!busADrv && !busBDrv));

  p_drive_b_r6: assert property (@(posedge capClkB) disable iff (!rstN)
    (!outEnN && dirAtoB) |-> (busBDrv && !busADrv));

  p_drive_a_r7: assert property (@(posedge capClkA) disable iff (!rstN)
    (!outEnN && !dirAtoB) |-> (busADrv && !busBDrv));

  p_live_ab_r8: assert property (@(posedge capClkB) disable iff (!rstN)
    !selStoredAB |-> (busBOut == busAIn));

  p_live_ba_r9: assert property (@(posedge capClkA) disable iff (!rstN)
    !selStoredBA |-> (busAOut == busBIn));

endmodule

bind dual_bus_xcvr dual_bus_xcvr_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/dual_bus_xcvr_test.sv
module dual_bus_xcvr_test;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN = 1'b0, capClkA = 1'b0, capClkB = 1'b0;
  logic outEnN = 1'b1, dirAtoB = 1'b0, selStoredAB = 1'b0, selStoredBA = 1'b0;
  logic [W-1:0] extA = '0, extB = '0;
  logic [W-1:0] padA, padB, busAOut, busBOut;
  logic busADrv, busBDrv;

  assign padA = busADrv ? busAOut : extA;
  assign padB = busBDrv ? busBOut : extB;

  dual_bus_xcvr #(.WIDTH(W)) uut (
    .rstN(rstN), .capClkA(capClkA), .capClkB(capClkB), .outEnN(outEnN),
    .dirAtoB(dirAtoB), .selStoredAB(selStoredAB), .selStoredBA(selStoredBA),
    .busAIn(padA), .busAOut(busAOut), .busADrv(busADrv),
    .busBIn(padB), .busBOut(busBOut), .busBDrv(busBDrv)
  );

  typedef struct {
    logic drvA; logic drvB; logic [W-1:0] valA; logic [W-1:0] valB; string req;
  } expItem_t;

  expItem_t sb[$];
  int total = 0, bad = 0;
  logic [W-1:0] mRegA = '0, mRegB = '0;
  bit done = 0;

  // Reference model built from the requirements
  function automatic logic mDrvA(); return !outEnN && !dirAtoB; endfunction
  function automatic logic mDrvB(); return !outEnN && dirAtoB; endfunction
  function automatic logic [W-1:0] mValA(); return selStoredBA ? mRegB : extB; endfunction
  function automatic logic [W-1:0] mValB(); return selStoredAB ? mRegA : extA; endfunction
  function automatic logic [W-1:0] mPadA(); return mDrvA() ? mValA() : extA; endfunction
  function automatic logic [W-1:0] mPadB(); return mDrvB() ? mValB() : extB; endfunction

  task automatic setCtl(input logic oe, input logic dir, input logic sab, input logic sba,
                        input logic [W-1:0] a, input logic [W-1:0] b);
    @(posedge clk); #1;
    outEnN = oe; dirAtoB = dir; selStoredAB = sab; selStoredBA = sba;
    extA = a; extB = b;
  endtask

  task automatic capture(input bit doA, input bit doB);
    logic [W-1:0] newA, newB;
    @(posedge clk); #5;
    newA = mPadA(); newB = mPadB();
    capClkA = doA; capClkB = doB;
    #5;
    capClkA = 1'b0; capClkB = 1'b0;
    if (doA) mRegA = newA;
    if (doB) mRegB = newB;
  endtask

  task automatic expectNow(input string req);
    expItem_t it;
    @(posedge clk); #2;
    it.drvA = mDrvA(); it.drvB = mDrvB();
    it.valA = mValA(); it.valB = mValB(); it.req = req;
    sb.push_back(it);
  endtask

  function automatic void checkOne(input bit ok, input string req, input string what,
                                   input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endfunction

  // Monitor: pops one expected item per cycle and compares at the falling edge
  always @(negedge clk) begin
    if (sb.size() > 0) begin
      expItem_t it;
      it = sb.pop_front();
      checkOne(busADrv == it.drvA, it.req, "busADrv", int'(busADrv), int'(it.drvA));
      checkOne(busBDrv == it.drvB, it.req, "busBDrv", int'(busBDrv), int'(it.drvB));
      checkOne(!(busADrv && busBDrv), "R10", "both drives", 1, 0);
      if (it.drvA) checkOne(busAOut == it.valA, it.req, "busAOut", int'(busAOut), int'(it.valA));
      if (it.drvB) checkOne(busBOut == it.valB, it.req, "busBOut", int'(busBOut), int'(it.valB));
    end
  end

  initial begin
    // R1: reset state seen through stored forwarding
    setCtl(1'b0, 1'b1, 1'b1, 1'b1, 8'h11, 8'h22);
    expectNow("R1 R6");
    setCtl(1'b0, 1'b0, 1'b1, 1'b1, 8'h11, 8'h22);
    expectNow("R1 R7");
    @(posedge clk); #1 rstN = 1'b1;

    // R5 and R4: isolation, loads still happen
    setCtl(1'b1, 1'b1, 1'b1, 1'b1, 8'h5A, 8'hC3);
    expectNow("R5");
    capture(1'b1, 1'b1);
    setCtl(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h00);
    expectNow("R5");
    setCtl(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    expectNow("R4 R2 R8");
    setCtl(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    expectNow("R4 R3 R9");

    // R8: live A to B, source changes between checks
    setCtl(1'b0, 1'b1, 1'b0, 1'b0, 8'h96, 8'h00);
    expectNow("R8 R6");
    setCtl(1'b0, 1'b1, 1'b0, 1'b0, 8'h11, 8'h00);
    expectNow("R8");

    // R9: live B to A
    setCtl(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h7E);
    expectNow("R9 R7");
    setCtl(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'h81);
    expectNow("R9");

    // R2: stored A held while live A changes
    setCtl(1'b0, 1'b1, 1'b1, 1'b0, 8'hA5, 8'h00);
    capture(1'b1, 1'b0);
    expectNow("R2 R8");
    setCtl(1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00);
    expectNow("R2 R8");

    // R11: B register loads the value driven onto B
    setCtl(1'b0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'hFF);
    capture(1'b0, 1'b1);
    setCtl(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    expectNow("R11");

    // R3 and R11: load B while passing it through to A
    setCtl(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, 8'hE1);
    capture(1'b0, 1'b1);
    expectNow("R3 R9");
    setCtl(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
    expectNow("R3 R11");

    // R1: asynchronous clear mid-run, no capture edge involved
    @(posedge clk); #1 rstN = 1'b0;
    mRegA = '0; mRegB = '0;
    #3 rstN = 1'b1;
    setCtl(1'b0, 1'b1, 1'b1, 1'b1, 8'h44, 8'h55);
    expectNow("R1");
    setCtl(1'b0, 1'b0, 1'b1, 1'b1, 8'h44, 8'h55);
    expectNow("R1");

    repeat (3) @(posedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule